// File: doc/BRIEF.md
# Banked Pointer Address Generator

This block forms data-memory addresses for a signal processor from eight 8-bit pointers. The pointers are split into two banks of four. Pointers 0 to 3 address bank 0 and pointers 4 to 7 address bank 1. A request names one pointer, an addressing mode and a 2-bit modifier. The block then does one of three things:
- returns the pointer value itself;
- reads the word the pointer addresses;
- reads that word, then reads a second word at the address held in its low byte.

The selected pointer can be stepped up or down after the access.

Two of the pointers, 3 and 7, are tied to the first word of their bank. For these two the modifier field holds a short immediate offset of 0 to 3. A separate write port loads the six writable pointers. Both RAM banks sit outside the block and are reached through a shared single-word read handshake. A bank select comes with each read request.

Top module: `bptr_agu`

## Requirements
- R1: After reset, every writable pointer holds 0 and `busy`, `done` and `ram_req` are low.
- R2: `req_sel[2]` selects the bank. Pointers 0–3 drive `ram_bank` = 0, and pointers 4–7 drive `ram_bank` = 1, for every RAM read of the operation.
- R3: `req_mode` = 00 (direct) returns the effective pointer on `res_addr`, and zero-extended on `res_data`. `done` pulses the cycle after acceptance, and no RAM read is issued.
- R4: `req_mode` = 01 (single) issues one read at the effective pointer. `res_data` is the returned word and `res_addr` its address. With a RAM that answers the cycle after `ram_req`, `done` comes 3 cycles after acceptance.
- R5: `req_mode` = 10 or 11 (double) issues a second read, in the same bank, at the low 8 bits of the first returned word. `busy` stays high until the second word returns. `res_data` and `res_addr` are taken from the second read, and `done` comes 5 cycles after acceptance.
- R6: Modifier codes: 00 none, 01 add one, 10 subtract one, 11 add one. The step is applied to the address used for the pointer, on the edge where `done` rises, and wraps modulo 256.
- R7: The write port (`wr_en`, `wr_sel`, `wr_data`) loads pointers 0, 1, 2, 4, 5 and 6. A write that names pointer 3 or 7 changes nothing.
- R8: For pointers 3 and 7 the effective pointer is the modifier code (0–3). No post-step is applied, and a double mode behaves as a single read.
- R9: When a load and a post-step reach the same pointer on the same edge, the loaded value is kept.
- R10: A request presented while `busy` is high is ignored. It produces no RAM read, no `done` and no pointer step.
- R11: `ram_req` is a one-cycle pulse and is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request, accepted when not busy |
| req_sel | input | 3 | Pointer number; bit 2 is the bank |
| req_mode | input | 2 | 00 direct, 01 single, 1x double |
| req_mod | input | 2 | Post-step code, or offset for pointers 3/7 |
| wr_en | input | 1 | Pointer load strobe |
| wr_sel | input | 3 | Pointer to load |
| wr_data | input | PTR_W | Load value |
| ram_req | output | 1 | RAM read request pulse |
| ram_bank | output | 1 | Bank for the read |
| ram_addr | output | PTR_W | Word address for the read |
| ram_rdata | input | DATA_W | Read word |
| ram_rvalid | input | 1 | Read word valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| res_data | output | DATA_W | Operand value |
| res_addr | output | PTR_W | Address of the operand (pointer value in direct mode) |

## Verification
Two functions can reach the same pointer register on one edge: the post-step at the end of an access, and a load from the write port. The bench provokes this by driving a direct access with an add-one modifier on pointer 1, while a load of 0x77 to pointer 1 is driven in the same cycle. It then reads pointer 1 back in direct mode and expects 0x77, not the stepped value. A second overlap is a new request held during a double read. It is judged by the absence of an extra `done`, and by the untouched value of the pointer that request would have stepped.

// File: rtl/bptr_pkg.sv
package bptr_pkg;

    localparam int NUM_PTR   = 8;
    localparam int SEL_W     = 3;
    localparam int DEF_PTR_W = 8;
    localparam int DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        MD_NONE    = 2'b00,
        MD_INC     = 2'b01,
        MD_DEC     = 2'b10,
        MD_INC_ALT = 2'b11
    } ptr_mod_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_FIRST  = 2'b01,
        S_SECOND = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             dbl;
        logic             fixed;
        ptr_mod_e         md;
    } op_ctx_t;

    // pointers 3 and 7 are tied to their bank base
    function automatic logic sel_is_fixed(input logic [SEL_W-1:0] s);
        return s[1:0] == 2'b11;
    endfunction

    function automatic logic mod_up(input ptr_mod_e m);
        return (m == MD_INC) || (m == MD_INC_ALT);
    endfunction

    function automatic logic mod_down(input ptr_mod_e m);
        return m == MD_DEC;
    endfunction

endpackage

// File: rtl/bptr_file.sv
module bptr_file
    import bptr_pkg::*;
#(
    parameter int PTR_W = DEF_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             upd_en,
    input  logic [SEL_W-1:0] upd_sel,
    input  logic [PTR_W-1:0] upd_val,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [1:0]       rd_mod,
    output logic [PTR_W-1:0] rd_ptr
);

    logic [PTR_W-1:0] regs [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        if ((g % 4) == 3) begin : g_fixed
            assign regs[g] = '0;
        end else begin : g_live
            logic [PTR_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    val_q <= '0;
                end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                    val_q <= wr_data;           // load beats post-step
                end else if (upd_en && (upd_sel == SEL_W'(g))) begin
                    val_q <= upd_val;
                end
            end
            assign regs[g] = val_q;
        end
    end

    always_comb begin
        if (sel_is_fixed(rd_sel)) begin
            rd_ptr = {{(PTR_W-2){1'b0}}, rd_mod};
        end else begin
            rd_ptr = regs[rd_sel];
        end
    end

endmodule

// File: rtl/bptr_seq.sv
module bptr_seq
    import bptr_pkg::*;
#(
    parameter int PTR_W  = DEF_PTR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        req_mode,
    input  logic [1:0]        req_mod,
    input  logic [PTR_W-1:0]  eff_ptr,
    output logic              ram_req,
    output logic              ram_bank,
    output logic [PTR_W-1:0]  ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              ram_rvalid,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_data,
    output logic [PTR_W-1:0]  res_addr,
    output logic              upd_en,
    output logic [SEL_W-1:0]  upd_sel,
    output logic [PTR_W-1:0]  upd_val
);

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input ptr_mod_e m);
        logic [PTR_W-1:0] delta;
        delta = mod_down(m) ? {PTR_W{1'b1}} : {{(PTR_W-1){1'b0}}, mod_up(m)};
        return p + delta;
    endfunction

    seq_state_e       state_q;
    op_ctx_t          ctx_q;
    logic [PTR_W-1:0] ptr_q;
    logic             accept;
    logic             finish;
    logic             req_fixed;
    ptr_mod_e         req_md;

    assign busy      = (state_q != S_IDLE);
    assign accept    = req_valid && (state_q == S_IDLE);
    assign req_fixed = sel_is_fixed(req_sel);
    assign req_md    = ptr_mod_e'(req_mod);
    assign finish    = ram_rvalid &&
                       (((state_q == S_FIRST) && !ctx_q.dbl) || (state_q == S_SECOND));

    always_comb begin
        upd_en  = 1'b0;
        upd_sel = ctx_q.sel;
        upd_val = step(ptr_q, ctx_q.md);
        if (accept && (req_mode == 2'b00)) begin
            upd_en  = !req_fixed;
            upd_sel = req_sel;
            upd_val = step(eff_ptr, req_md);
        end else if (finish) begin
            upd_en  = !ctx_q.fixed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            ctx_q    <= '0;
            ptr_q    <= '0;
            ram_req  <= 1'b0;
            ram_bank <= 1'b0;
            ram_addr <= '0;
            done     <= 1'b0;
            res_data <= '0;
            res_addr <= '0;
        end else begin
            ram_req <= 1'b0;
            done    <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        ctx_q    <= '{sel: req_sel, dbl: req_mode[1] && !req_fixed,
                                      fixed: req_fixed, md: req_md};
                        ptr_q    <= eff_ptr;
                        ram_bank <= req_sel[SEL_W-1];
                        if (req_mode == 2'b00) begin
                            done     <= 1'b1;
                            res_data <= {{(DATA_W-PTR_W){1'b0}}, eff_ptr};
                            res_addr <= eff_ptr;
                        end else begin
                            state_q  <= S_FIRST;
                            ram_req  <= 1'b1;
                            ram_addr <= eff_ptr;
                        end
                    end
                end
                S_FIRST: begin
                    if (ram_rvalid) begin
                        if (ctx_q.dbl) begin
                            state_q  <= S_SECOND;
                            ram_req  <= 1'b1;
                            ram_addr <= ram_rdata[PTR_W-1:0];
                        end else begin
                            state_q  <= S_IDLE;
                            done     <= 1'b1;
                            res_data <= ram_rdata;
                            res_addr <= ram_addr;
                        end
                    end
                end
                S_SECOND: begin
                    if (ram_rvalid) begin
                        state_q  <= S_IDLE;
                        done     <= 1'b1;
                        res_data <= ram_rdata;
                        res_addr <= ram_addr;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bptr_agu.sv
module bptr_agu
    import bptr_pkg::*;
#(
    parameter int PTR_W  = DEF_PTR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_sel,
    input  logic [1:0]        req_mode,
    input  logic [1:0]        req_mod,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [PTR_W-1:0]  wr_data,
    output logic              ram_req,
    output logic              ram_bank,
    output logic [PTR_W-1:0]  ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              ram_rvalid,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_data,
    output logic [PTR_W-1:0]  res_addr
);

    logic [PTR_W-1:0] eff_ptr;
    logic             upd_en;
    logic [SEL_W-1:0] upd_sel;
    logic [PTR_W-1:0] upd_val;

    bptr_file #(.PTR_W(PTR_W)) u_file (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_sel (upd_sel),
        .upd_val (upd_val),
        .rd_sel  (req_sel),
        .rd_mod  (req_mod),
        .rd_ptr  (eff_ptr)
    );

    bptr_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .req_mode   (req_mode),
        .req_mod    (req_mod),
        .eff_ptr    (eff_ptr),
        .ram_req    (ram_req),
        .ram_bank   (ram_bank),
        .ram_addr   (ram_addr),
        .ram_rdata  (ram_rdata),
        .ram_rvalid (ram_rvalid),
        .busy       (busy),
        .done       (done),
        .res_data   (res_data),
        .res_addr   (res_addr),
        .upd_en     (upd_en),
        .upd_sel    (upd_sel),
        .upd_val    (upd_val)
    );

endmodule

// File: rtl/bptr_agu_chk.sv
module bptr_agu_chk #(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_sel,
    input logic [1:0]        req_mode,
    input logic [1:0]        req_mod,
    input logic              ram_req,
    input logic              ram_bank,
    input logic [PTR_W-1:0]  ram_addr,
    input logic              busy,
    input logic              done
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ram_req));

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (rst)
        ram_req |=> !ram_req);

    a_r11_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> busy);

    a_r2_bank_follows_sel: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_mode != 2'b00))
        |=> (ram_req && (ram_bank == $past(req_sel[2]))));

    a_r8_fixed_offset: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_mode != 2'b00) && (req_sel[1:0] == 2'b11))
        |=> (ram_addr == {{(PTR_W-2){1'b0}}, $past(req_mod)}));

    a_r3_direct_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_mode == 2'b00))
        |=> (done && !busy && !ram_req));

    a_r10_busy_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

endmodule

bind bptr_agu bptr_agu_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_mode  (req_mode),
    .req_mod   (req_mod),
    .ram_req   (ram_req),
    .ram_bank  (ram_bank),
    .ram_addr  (ram_addr),
    .busy      (busy),
    .done      (done)
);

// File: tb/bptr_agu_bench.sv
module bptr_agu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int DW = 16;
    localparam int NVEC = 16;

    // {sel[2:0], mode[1:0], mod[1:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        {3'd0, 2'b00, 2'b00}, {3'd0, 2'b01, 2'b01}, {3'd0, 2'b10, 2'b00},
        {3'd2, 2'b01, 2'b01}, {3'd2, 2'b00, 2'b00}, {3'd4, 2'b01, 2'b10},
        {3'd4, 2'b00, 2'b00}, {3'd5, 2'b11, 2'b11}, {3'd6, 2'b10, 2'b10},
        {3'd3, 2'b01, 2'b10}, {3'd7, 2'b11, 2'b11}, {3'd7, 2'b00, 2'b01},
        {3'd1, 2'b00, 2'b01}, {3'd1, 2'b00, 2'b00}, {3'd3, 2'b00, 2'b11},
        {3'd7, 2'b00, 2'b00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_sel = '0;
    logic [1:0]    req_mode = '0;
    logic [1:0]    req_mod = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [PW-1:0] wr_data = '0;
    logic          ram_req, ram_bank, busy, done;
    logic [PW-1:0] ram_addr, res_addr;
    logic [DW-1:0] ram_rdata, res_data;
    logic          ram_rvalid;

    int checks = 0;
    int failures = 0;
    logic [PW-1:0] model_ptr [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bptr_agu u_bptr_agu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .req_mod(req_mod), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ram_req(ram_req), .ram_bank(ram_bank),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_rvalid(ram_rvalid),
        .busy(busy), .done(done), .res_data(res_data), .res_addr(res_addr)
    );

    function automatic logic [DW-1:0] mem_word(input logic b, input logic [PW-1:0] a);
        return {a ^ (b ? 8'hF0 : 8'h0F), a + 8'h11};
    endfunction

    // RAM model: one-cycle read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_rvalid <= 1'b0;
            ram_rdata  <= '0;
        end else begin
            ram_rvalid <= ram_req;
            ram_rdata  <= mem_word(ram_bank, ram_addr);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [2:0] s, input logic [PW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (s[1:0] != 2'b11) model_ptr[s] = v;
    endtask

    task automatic run_op(input logic [2:0] s, input logic [1:0] m, input logic [1:0] md,
                          output logic [DW-1:0] d, output logic [PW-1:0] a,
                          output int lat, output logic gap);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_mode = m; req_mod = md;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; gap = 1'b0;
        while (!done && lat < 20) begin
            if (!busy) gap = 1'b1;
            @(negedge clk);
            lat++;
        end
        d = res_data; a = res_addr;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d, ed;
        logic [PW-1:0] a, ea, p;
        int lat, el, dcount;
        logic gap, fx, bk;
        for (int i = 0; i < 8; i++) model_ptr[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 ram_req after reset", ram_req, 0);
        run_op(3'd5, 2'b00, 2'b00, d, a, lat, gap);
        check("R1 pointer 5 reset value", d, 0);

        // R7 loads; pointers 3 and 7 ignore writes
        load_ptr(3'd0, 8'h10); load_ptr(3'd1, 8'h20); load_ptr(3'd2, 8'hFF);
        load_ptr(3'd4, 8'h00); load_ptr(3'd5, 8'h80); load_ptr(3'd6, 8'h01);
        load_ptr(3'd3, 8'h55); load_ptr(3'd7, 8'hAA);

        // table walk: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] s; logic [1:0] m, md;
            {s, m, md} = VEC[v];
            fx = (s[1:0] == 2'b11);
            bk = s[2];
            p  = fx ? {6'b0, md} : model_ptr[s];
            if (m == 2'b00) begin
                ed = {8'h00, p}; ea = p; el = 1;
            end else if (m[1] && !fx) begin
                ea = mem_word(bk, p)[PW-1:0];
                ed = mem_word(bk, ea); el = 5;
            end else begin
                ea = p; ed = mem_word(bk, p); el = 3;
            end
            if (!fx) begin
                if (md == 2'b10) model_ptr[s] = p - 8'd1;
                else if (md != 2'b00) model_ptr[s] = p + 8'd1;
            end
            run_op(s, m, md, d, a, lat, gap);
            check($sformatf("R2/R6/R8 vec%0d res_data", v), d, ed);
            check($sformatf("R3/R4/R5 vec%0d res_addr", v), a, ea);
            check($sformatf("R3/R4/R5 vec%0d latency", v), lat, el);
            if (m != 2'b00) check($sformatf("R5 vec%0d busy held", v), gap, 0);
        end

        // R6 wrap down and up confirmed by pointer reads
        run_op(3'd4, 2'b00, 2'b00, d, a, lat, gap);
        check("R6 pointer 4 wrapped to FF", d, 16'h00FF);
        run_op(3'd2, 2'b00, 2'b00, d, a, lat, gap);
        check("R6 pointer 2 wrapped to 00", d, 16'h0000);
        // R8 no post-step on fixed pointer
        run_op(3'd3, 2'b00, 2'b00, d, a, lat, gap);
        check("R8 pointer 3 stays at base", d, 0);

        // R9 load and post-step on the same edge
        @(negedge clk);
        req_valid = 1'b1; req_sel = 3'd1; req_mode = 2'b00; req_mod = 2'b01;
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h77;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R9 result uses old pointer", res_data, {8'h00, model_ptr[1]});
        model_ptr[1] = 8'h77;
        run_op(3'd1, 2'b00, 2'b00, d, a, lat, gap);
        check("R9 load wins over post-step", d, 16'h0077);

        // R10 request while busy is ignored
        p = model_ptr[5];
        dcount = 0;
        @(negedge clk);
        req_valid = 1'b1; req_sel = 3'd0; req_mode = 2'b10; req_mod = 2'b00;
        @(negedge clk);
        req_sel = 3'd5; req_mode = 2'b00; req_mod = 2'b01;
        @(negedge clk);
        if (done) dcount++;
        @(negedge clk);
        req_valid = 1'b0;
        if (done) dcount++;
        repeat (4) begin
            @(negedge clk);
            if (done) dcount++;
        end
        check("R10 single done for held request", dcount, 1);
        run_op(3'd5, 2'b00, 2'b00, d, a, lat, gap);
        check("R10 pointer 5 not stepped", d, {8'h00, p});

        // R11 no stray request when idle
        @(negedge clk);
        check("R11 ram_req idle low", ram_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule